// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block keeps an asynchronous DRAM alive. It sits beside the access sequencer that serves host reads and writes. Refresh is done by pulling the column strobe low ahead of the row strobe. In that mode the device picks the row from its own counter, so the block drives no address. The block asks for the memory bus with a request line and waits for the sequencer's grant, so an access already in progress always finishes first. While it holds the grant, it drives the row strobe, column strobe and write enable directly.

After reset the block keeps the row strobe high for a fixed pause. It then runs a train of dummy refresh cycles and only after that raises an init-done flag. Host requests are refused until the flag is high. In normal running a timer raises one refresh request per interval. If the bus is busy, the requests pile up in a bounded pending counter and are later served back to back. A hold input stops refresh. If both row strobes seen by the DRAM then stay high for longer than an idle limit, init-done drops and the dummy train runs again once the hold is released. Every timing figure is given in nanoseconds and converted to clock cycles from the clock-frequency parameter.

Top module: `dram_refresh_sched`

## Requirements
- R1: During the power-up pause after reset (PAUSE_NS worth of cycles), `ref_ras_n` and `ref_cas_n` stay high, `ref_req` stays low and `init_done` stays low.
- R2: When the pause ends, exactly DUMMY_CYCLES refresh cycles run before `init_done` rises. `init_done` goes high on the clock edge that closes the precharge of the last dummy cycle.
- R3: Each refresh cycle has the following shape. `ref_cas_n` is low in the clock before `ref_ras_n` falls and stays low for the first ceil(CAS_HOLD_NS) cycles of the row pulse. The row pulse lasts ceil(RAS_MIN_NS) cycles. The row strobe is then high for at least max(ceil(PRE_MIN_NS), ceil(CYCLE_MIN_NS) - 1 - row cycles) cycles. With the bench's values these are 2, 10 and 8 cycles.
- R4: `ref_we_n` is high at all times, including the moment the row strobe falls.
- R5: A refresh cycle starts only in a clock where `ref_gnt` is high. `ref_drive` is high whenever either strobe driven by the block is low. While no grant is given, both strobes stay high.
- R6: After `init_done`, one refresh becomes due every floor(REF_PERIOD_NS) cycles. Refreshes that are due but not yet granted are held, up to PEND_DEPTH; further ones are dropped. Once the grant arrives, all held refreshes run back to back.
- R7: `host_ack` is high only when `host_req` is high, `init_done` is high and `ref_req` is low.
- R8: While `refresh_hold` is high, no refresh becomes due and no new cycle starts. When `ref_ras_n` and `acc_ras_n` have both been high for floor(IDLE_LIMIT_NS) cycles, `init_done` falls. After the hold is released, DUMMY_CYCLES refresh cycles run and then `init_done` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its frequency is the CLK_MHZ parameter |
| rst_n | input | 1 | Synchronous active-low reset; low at power-up |
| refresh_hold | input | 1 | Suspends refresh while high |
| ref_gnt | input | 1 | Bus grant from the access sequencer |
| acc_ras_n | input | 1 | Row strobe as driven by the access sequencer (watched for idle) |
| host_req | input | 1 | Host wants to start an access |
| ref_req | output | 1 | Bus request for refresh |
| ref_drive | output | 1 | Block is driving the DRAM strobes |
| ref_ras_n | output | 1 | Row strobe from this block |
| ref_cas_n | output | 1 | Column strobe from this block |
| ref_we_n | output | 1 | Write enable from this block (held high) |
| init_done | output | 1 | Power-up or wake sequence complete |
| host_ack | output | 1 | Host access may start |

## Verification
The bench uses CLK_MHZ = 100 and shrinks the slow timing parameters: REF_PERIOD_NS = 3000 (300 cycles), PAUSE_NS = 2000 (200 cycles) and IDLE_LIMIT_NS = 20000 (2000 cycles). All other parameters keep their defaults. With these values, one short run reaches a grant denied for nine refresh intervals, which overflows the four-entry pending counter, and a hold long enough to expire the idle limit and trigger the second dummy train. The strobe shape is measured on every cycle, dummy or periodic, against the default row, column-hold and precharge lengths.

// File: rtl/dram_ref_pkg.sv
// Package: shared types and ns-to-cycle conversions for the refresh scheduler.
// Assumes clock frequencies are whole MHz.
package dram_ref_pkg;

    // Phase of one column-before-row refresh cycle.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_PRECH  = 2'd3
    } cbr_phase_t;

    // Top-level boot / run state.
    typedef enum logic [1:0] {
        BOOT_PAUSE = 2'd0,
        BOOT_WARM  = 2'd1,
        BOOT_RUN   = 2'd2
    } boot_state_t;

    // Minimum times round up so the DRAM never sees a short pulse.
    function automatic int unsigned cyc_ceil(longint unsigned ns, int unsigned mhz);
        longint unsigned prod;
        prod = ns * longint'(mhz);
        return int'((prod + 64'd999) / 64'd1000);
    endfunction

    // Maximum intervals round down so refresh is never late.
    function automatic int unsigned cyc_floor(longint unsigned ns, int unsigned mhz);
        longint unsigned prod;
        prod = ns * longint'(mhz);
        return int'(prod / 64'd1000);
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ref_interval_timer.sv
// Module: ref_interval_timer
// Produces a one-clock tick every PERIOD cycles while enabled.
// Restarts from zero whenever it is disabled.
// Assumes PERIOD >= 2.
module ref_interval_timer #(
    parameter int unsigned PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = $clog2(PERIOD + 1);

    logic [CW-1:0] cnt;

    // Count enabled cycles and wrap at the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == CW'(PERIOD - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == CW'(PERIOD - 1));

    // R6: ticks are never adjacent
    a_r6_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/ref_pending_ctr.sv
// Module: ref_pending_ctr
// Holds the number of refreshes that are due but not yet run.
// Saturates at DEPTH, so further increments are dropped.
// Never underflows.
module ref_pending_ctr #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic nonzero
);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    logic [LW-1:0] level;

    // Saturating up/down count of pending refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            level <= '0;
        end else if (inc && !dec && level != LW'(DEPTH)) begin
            level <= level + 1'b1;
        end else if (dec && !inc && level != '0) begin
            level <= level - 1'b1;
        end
    end

    assign nonzero = (level != '0);

    // R6: a full counter stays full when another refresh becomes due
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LW'(DEPTH) && inc && !dec && !clr) |=> (level == LW'(DEPTH)));

    // R6: one completion takes exactly one pending refresh away
    a_r6_one_per_done: assert property (@(posedge clk) disable iff (!rst_n)
        (level != '0 && dec && !inc && !clr) |=> (level == $past(level) - 1'b1));

endmodule

// File: rtl/ref_idle_watch.sv
// Module: ref_idle_watch
// Counts consecutive cycles with the DRAM row strobe high.
// Flags expiry once LIMIT cycles have passed; the count saturates there.
module ref_idle_watch #(
    parameter int unsigned LIMIT = 800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_high,
    output logic expired
);
    localparam int unsigned IW = $clog2(LIMIT + 1);

    logic [IW-1:0] cnt;

    // Saturating run-length of row-strobe-high cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !line_high) begin
            cnt <= '0;
        end else if (cnt != IW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == IW'(LIMIT));

    // R8: expiry ends as soon as the row strobe goes low
    a_r8_clear_on_activity: assert property (@(posedge clk) disable iff (!rst_n)
        !line_high |=> !expired);

endmodule

// File: rtl/cbr_strobe_seq.sv
// Module: cbr_strobe_seq
// Runs one refresh cycle with the column strobe low before the row strobe.
// Phases: column setup, row active, precharge.
// Strobe outputs are registered, so they come out without glitches.
// Assumes CHOLD_CYC < RAS_CYC.
// Assumes `go` is only sampled while idle.
module cbr_strobe_seq
    import dram_ref_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned RAS_CYC   = 10,
    parameter int unsigned CHOLD_CYC = 2,
    parameter int unsigned PRE_CYC   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic ras_n,
    output logic cas_n,
    output logic busy,
    output logic done
);
    localparam int unsigned MAXC = max_u(max_u(SETUP_CYC, RAS_CYC), PRE_CYC);
    localparam int unsigned CW   = $clog2(MAXC + 1);

    cbr_phase_t    phase, phase_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // Next phase and phase counter.
    always_comb begin
        phase_nx = phase;
        cnt_nx   = cnt + 1'b1;
        unique case (phase)
            PH_IDLE: begin
                cnt_nx = '0;
                if (go) phase_nx = PH_SETUP;
            end
            PH_SETUP: begin
                if (cnt == CW'(SETUP_CYC - 1)) begin
                    phase_nx = PH_ACTIVE;
                    cnt_nx   = '0;
                end
            end
            PH_ACTIVE: begin
                if (cnt == CW'(RAS_CYC - 1)) begin
                    phase_nx = PH_PRECH;
                    cnt_nx   = '0;
                end
            end
            PH_PRECH: begin
                if (cnt == CW'(PRE_CYC - 1)) begin
                    phase_nx = PH_IDLE;
                    cnt_nx   = '0;
                end
            end
            default: begin
                phase_nx = PH_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // Register phase, counter and the strobes decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
        end else begin
            phase <= phase_nx;
            cnt   <= cnt_nx;
            ras_n <= (phase_nx != PH_ACTIVE);
            cas_n <= !((phase_nx == PH_SETUP) ||
                       ((phase_nx == PH_ACTIVE) && (cnt_nx < CW'(CHOLD_CYC))));
        end
    end

    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_PRECH) && (cnt == CW'(PRE_CYC - 1));

    // Checker state: length of the current row pulse.
    logic [15:0] low_len;
    always_ff @(posedge clk) begin
        if (!rst_n || ras_n) low_len <= '0;
        else                 low_len <= low_len + 1'b1;
    end

    // R3: column strobe already low in the clock before the row strobe falls
    a_r3_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    // R3: column strobe is released while the row strobe is still low
    a_r3_cas_hold_inside: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> !ras_n);

    // R3: row pulse width in cycles
    a_r3_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_len == 16'(RAS_CYC)));

endmodule

// File: rtl/dram_refresh_sched.sv
// Module: dram_refresh_sched (top)
// Schedules column-before-row refresh for an asynchronous DRAM.
// Runs the power-up pause and dummy-cycle train, then issues periodic
// refreshes through a request/grant handshake with the access sequencer.
// Assumes the sequencer keeps ref_gnt high for as long as ref_req is high
// once it has granted.
// All times are in ns and converted with CLK_MHZ.
module dram_refresh_sched
    import dram_ref_pkg::*;
#(
    parameter int unsigned CLK_MHZ       = 100,
    parameter int unsigned REF_PERIOD_NS = 15600,
    parameter int unsigned PAUSE_NS      = 200000,
    parameter int unsigned IDLE_LIMIT_NS = 8000000,
    parameter int unsigned RAS_MIN_NS    = 100,
    parameter int unsigned PRE_MIN_NS    = 80,
    parameter int unsigned CYCLE_MIN_NS  = 190,
    parameter int unsigned CAS_HOLD_NS   = 20,
    parameter int unsigned DUMMY_CYCLES  = 8,
    parameter int unsigned PEND_DEPTH    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refresh_hold,
    input  logic ref_gnt,
    input  logic acc_ras_n,
    input  logic host_req,
    output logic ref_req,
    output logic ref_drive,
    output logic ref_ras_n,
    output logic ref_cas_n,
    output logic ref_we_n,
    output logic init_done,
    output logic host_ack
);
    localparam int unsigned SETUP_CYC = 1;
    localparam int unsigned CHOLD_CYC = max_u(1, cyc_ceil(CAS_HOLD_NS, CLK_MHZ));
    localparam int unsigned RAS_CYC   = max_u(CHOLD_CYC + 1, cyc_ceil(RAS_MIN_NS, CLK_MHZ));
    localparam int unsigned TOT_CYC   = cyc_ceil(CYCLE_MIN_NS, CLK_MHZ);
    localparam int unsigned PRE_REST  = (TOT_CYC > SETUP_CYC + RAS_CYC) ?
                                        (TOT_CYC - SETUP_CYC - RAS_CYC) : 1;
    localparam int unsigned PRE_CYC   = max_u(max_u(1, cyc_ceil(PRE_MIN_NS, CLK_MHZ)), PRE_REST);
    localparam int unsigned INT_CYC   = max_u(2, cyc_floor(REF_PERIOD_NS, CLK_MHZ));
    localparam int unsigned PAUSE_CYC = max_u(1, cyc_ceil(PAUSE_NS, CLK_MHZ));
    localparam int unsigned IDLE_CYC  = max_u(1, cyc_floor(IDLE_LIMIT_NS, CLK_MHZ));
    localparam int unsigned PW        = $clog2(PAUSE_CYC + 1);
    localparam int unsigned DW        = $clog2(DUMMY_CYCLES + 1);

    boot_state_t   state;
    logic [PW-1:0] pause_cnt;
    logic [DW-1:0] dummy_left;

    logic run, tick, pend_nz, work, go, seq_busy, seq_done, idle_expired;

    assign run  = (state == BOOT_RUN);
    assign work = ((state == BOOT_WARM) && (dummy_left != '0)) || (run && pend_nz);
    assign go   = work && !refresh_hold && ref_gnt;

    // Refresh interval timer: only runs in normal operation when not held.
    ref_interval_timer #(.PERIOD(INT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run && !refresh_hold),
        .tick  (tick)
    );

    // Pending refreshes; cleared whenever not in normal operation.
    ref_pending_ctr #(.DEPTH(PEND_DEPTH)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!run),
        .inc     (tick),
        .dec     (seq_done),
        .nonzero (pend_nz)
    );

    // Strobe sequencer for a single refresh cycle.
    cbr_strobe_seq #(
        .SETUP_CYC (SETUP_CYC),
        .RAS_CYC   (RAS_CYC),
        .CHOLD_CYC (CHOLD_CYC),
        .PRE_CYC   (PRE_CYC)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .ras_n (ref_ras_n),
        .cas_n (ref_cas_n),
        .busy  (seq_busy),
        .done  (seq_done)
    );

    // Idle watch on the row strobe as the DRAM sees it.
    ref_idle_watch #(.LIMIT(IDLE_CYC)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_high (ref_ras_n && acc_ras_n),
        .expired   (idle_expired)
    );

    // Boot controller: pause, dummy train, run, and re-warm after idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= BOOT_PAUSE;
            pause_cnt  <= '0;
            dummy_left <= '0;
        end else begin
            unique case (state)
                BOOT_PAUSE: begin
                    if (pause_cnt == PW'(PAUSE_CYC - 1)) begin
                        state      <= BOOT_WARM;
                        dummy_left <= DW'(DUMMY_CYCLES);
                    end else begin
                        pause_cnt <= pause_cnt + 1'b1;
                    end
                end
                BOOT_WARM: begin
                    if (seq_done) begin
                        dummy_left <= dummy_left - 1'b1;
                        if (dummy_left == DW'(1)) state <= BOOT_RUN;
                    end
                end
                BOOT_RUN: begin
                    if (idle_expired) begin
                        state      <= BOOT_WARM;
                        dummy_left <= DW'(DUMMY_CYCLES);
                    end
                end
                default: state <= BOOT_PAUSE;
            endcase
        end
    end

    assign ref_req   = seq_busy || (work && !refresh_hold);
    assign ref_drive = seq_busy;
    assign ref_we_n  = 1'b1;
    assign init_done = run;
    assign host_ack  = host_req && run && !ref_req;

    // R1: the pause leaves the strobes high and the bus alone
    a_r1_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BOOT_PAUSE) |-> (ref_ras_n && ref_cas_n && !ref_req));

    // R2: init-done only rises right after a refresh completes
    a_r2_ready_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(seq_done));

    // R5: a cycle starts only after a grant
    a_r5_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_cas_n) |-> $past(ref_gnt));

    // R5: the drive flag covers every low strobe
    a_r5_drive_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_ras_n || !ref_cas_n) |-> ref_drive);

    // R8: init-done only falls after the idle limit has expired
    a_r8_drop_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_done) |-> $past(idle_expired));

    // R8: no cycle starts while held
    a_r8_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_hold && !ref_drive) |=> ref_cas_n);

endmodule

// File: tb/sim_dram_refresh_sched.sv
// Scoreboard bench: the driver pushes expected refresh counts.
// A monitor pops them at checkpoints and compares them with the refresh cycles it saw.
module sim_dram_refresh_sched;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic refresh_hold = 1'b0;
    logic acc_ras_n = 1'b1;
    logic host_req = 1'b0;
    logic gnt_allow = 1'b0;
    logic ref_gnt, ref_req, ref_drive, ref_ras_n, ref_cas_n, ref_we_n, init_done, host_ack;

    always #5 clk = ~clk;

    assign ref_gnt = ref_req & gnt_allow;

    dram_refresh_sched #(
        .CLK_MHZ       (100),
        .REF_PERIOD_NS (3000),
        .PAUSE_NS      (2000),
        .IDLE_LIMIT_NS (20000)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .refresh_hold (refresh_hold),
        .ref_gnt      (ref_gnt),
        .acc_ras_n    (acc_ras_n),
        .host_req     (host_req),
        .ref_req      (ref_req),
        .ref_drive    (ref_drive),
        .ref_ras_n    (ref_ras_n),
        .ref_cas_n    (ref_cas_n),
        .ref_we_n     (ref_we_n),
        .init_done    (init_done),
        .host_ack     (host_ack)
    );

    localparam int RAS_LEN = 10;
    localparam int CHOLD   = 2;
    localparam int PRE_MIN = 8;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit finished = 1'b0;
    bit acc_en   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Scoreboard queue of expected refresh counts.
    typedef struct {
        int    n;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    event ckpt;
    int   ref_seen  = 0;
    int   base_seen = 0;

    task automatic expect_refreshes(input int n, input string tag);
        exp_t e;
        e.n = n;
        e.tag = tag;
        exp_q.push_back(e);
        -> ckpt;
        #1;
    endtask

    // Monitor: compares the refresh cycles counted since the last checkpoint.
    initial begin
        forever begin
            exp_t e;
            @(ckpt);
            e = exp_q.pop_front();
            chk((ref_seen - base_seen) == e.n, e.tag, "refresh count",
                ref_seen - base_seen, e.n);
            base_seen = ref_seen;
        end
    end

    // Monitor: measures the shape of every refresh cycle (R3, R4, R5).
    int   lo_len = 0;
    int   cas_hold = 0;
    int   hi_len = 1000;
    logic p_ras = 1'b1;
    logic p_cas = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !ref_ras_n) begin
                ref_seen++;
                chk(p_cas == 1'b0, "R3", "cas low before ras fall", int'(p_cas), 0);
                chk(ref_we_n == 1'b1, "R4", "we high at ras fall", int'(ref_we_n), 1);
                chk(ref_gnt == 1'b1, "R5", "grant at ras fall", int'(ref_gnt), 1);
                chk(ref_drive == 1'b1, "R5", "drive at ras fall", int'(ref_drive), 1);
                chk(hi_len >= PRE_MIN, "R3", "precharge length", hi_len, PRE_MIN);
                lo_len = 1;
                cas_hold = ref_cas_n ? 0 : 1;
            end else if (!ref_ras_n) begin
                lo_len++;
                if (!ref_cas_n) cas_hold++;
            end
            if (!p_ras && ref_ras_n) begin
                chk(lo_len == RAS_LEN, "R3", "row pulse length", lo_len, RAS_LEN);
                chk(cas_hold == CHOLD, "R3", "column hold length", cas_hold, CHOLD);
                hi_len = 1;
            end else if (ref_ras_n) begin
                hi_len++;
            end
            p_ras = ref_ras_n;
            p_cas = ref_cas_n;
        end
    end

    // Emulated host accesses pulse the sequencer's row strobe.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (acc_en && (cyc % 500 == 0)) acc_ras_n = 1'b0;
            else if (cyc % 500 == 3)        acc_ras_n = 1'b1;
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    int t0 = 0;
    int t_run = 0;

    task automatic go_to(input int rel);
        while (cyc < t_run + rel) begin
            @(posedge clk);
            #2;
        end
    endtask

    // Driver.
    initial begin
        repeat (4) @(posedge clk);
        #2;
        chk(ref_ras_n && ref_cas_n, "R1", "strobes high in reset", int'(ref_ras_n & ref_cas_n), 1);
        chk(ref_we_n == 1'b1, "R4", "we high in reset", int'(ref_we_n), 1);
        chk(!ref_req && !init_done, "R1", "req/init low in reset", int'(ref_req | init_done), 0);
        rst_n = 1'b1;
        t0 = cyc;
        host_req = 1'b1;
        t_run = t0;
        go_to(150);
        chk(ref_req == 1'b0, "R1", "no request during pause", int'(ref_req), 0);
        chk(ref_ras_n == 1'b1, "R1", "row strobe high during pause", int'(ref_ras_n), 1);
        chk(init_done == 1'b0, "R1", "init low during pause", int'(init_done), 0);
        chk(host_ack == 1'b0, "R7", "host refused before init", int'(host_ack), 0);
        gnt_allow = 1'b1;
        while (!init_done) begin
            @(posedge clk);
            #2;
        end
        t_run = cyc;
        chk((t_run - t0) >= 355 && (t_run - t0) <= 365, "R2", "init-done time",
            t_run - t0, 360);
        expect_refreshes(8, "R2");
        go_to(5);
        chk(host_ack == 1'b1, "R7", "host accepted when idle", int'(host_ack), 1);
        go_to(1000);
        expect_refreshes(3, "R6");
        gnt_allow = 1'b0;
        acc_en = 1'b1;
        go_to(3000);
        chk(host_ack == 1'b0, "R7", "host refused while refresh pending", int'(host_ack), 0);
        chk(ref_req == 1'b1, "R6", "request held while denied", int'(ref_req), 1);
        chk(ref_ras_n && ref_cas_n, "R5", "no strobe without grant",
            int'(ref_ras_n & ref_cas_n), 1);
        go_to(3620);
        gnt_allow = 1'b1;
        go_to(3720);
        expect_refreshes(4, "R6");
        gnt_allow = 1'b0;
        go_to(4350);
        gnt_allow = 1'b1;
        go_to(4450);
        expect_refreshes(2, "R6");
        refresh_hold = 1'b1;
        acc_en = 1'b0;
        go_to(5950);
        chk(init_done == 1'b1, "R8", "init still high before idle limit", int'(init_done), 1);
        expect_refreshes(0, "R8");
        go_to(6550);
        chk(init_done == 1'b0, "R8", "init dropped after idle limit", int'(init_done), 0);
        chk(host_ack == 1'b0, "R7", "host refused after idle drop", int'(host_ack), 0);
        go_to(6600);
        refresh_hold = 1'b0;
        go_to(6800);
        chk(init_done == 1'b1, "R8", "init back after wake train", int'(init_done), 1);
        expect_refreshes(8, "R8");
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

endmodule